// File: doc/BRIEF.md
# Homodyne Quadrature Down-Converter with Digital Gain Control

This block turns a stream of 16-bit signed converter samples into a decimated baseband in-phase/quadrature pair. Each sample is multiplied by a quadrature local oscillator. The oscillator is given as a two-bit phase quadrant that runs in lock with the sample clock, so the selected harmonic lands at zero frequency with its amplitude and phase kept. The two mixer products each pass through a three-stage cascaded integrator-comb decimator. The decimation ratio is programmable, and each result is cut down to an 18-bit word.

Ahead of the mixer, a digital gain control shifts each sample left by 0 to 3 bits, which is 6 dB per step. This keeps weak signals high in the word before the narrowband filter, so quantisation noise is a smaller share of the result. The gain is re-evaluated once per output interval, from the peak magnitude seen after the shift. The shift in force is reported with every output pair so that later stages can undo it.

Top module: `ddc_agc_top`

## Requirements
- R1: While rst_n is low, out_valid, out_i, out_q and out_gain are all zero.
- R2: Mixer: the quadrant code lo_quad picks (cos, sin) as 0:(1,0), 1:(0,1), 2:(-1,0), 3:(0,-1). The in-phase path receives s·cos and the quadrature path receives -s·sin, where s is the sample after the gain shift.
- R3: Decimator: once the input has been steady for three intervals, each output equals floor(M·R³ / 2^20). Here M is the mean of the mixer product over an interval of R accepted samples, and the value is carried as a two's complement 18-bit word.
- R4: The effective ratio R is dec_ratio clamped to the range 4 to 64. out_valid pulses for one cycle per R accepted samples.
- R5: A cycle with in_valid low is ignored. It does not advance the interval and does not change any result.
- R6: When the shifted peak stays below 8192 for 16 intervals in a row, the shift rises by one step, up to a maximum of 3.
- R7: When the shifted peak of an interval exceeds 16384, the shift drops by one step at the end of that interval, down to a minimum of 0. A peak between the two thresholds restarts the count for R6.
- R8: The internal shift changes only at the end of an interval, and by at most one step.
- R9: out_gain, sampled with each out_valid, shows the shift that is in force after the interval that pulse closes has been evaluated. It changes only together with out_valid.
- R10: out_i and out_q hold their values in every cycle where out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample qualifier |
| in_sample | input | 16 | Signed converter sample |
| lo_quad | input | 2 | Local-oscillator phase quadrant |
| dec_ratio | input | 7 | Requested decimation ratio |
| out_valid | output | 1 | One-cycle strobe for a new I/Q pair |
| out_i | output | 18 | In-phase result, signed |
| out_q | output | 18 | Quadrature result, signed |
| out_gain | output | 2 | Gain shift applied to this pair |

## Verification
Some rules are checked on every cycle. The shift moves only at an interval end and by no more than one step. Strobes are never back to back. The outputs and the reported shift stay still between strobes. Other behaviour only the bench scenarios can show. These are the exact decimated values for each oscillator quadrant and for locked tones, the 16-interval climb of the shift and its cap, the drop on overload, the ratio clamp at both ends, and how much the input qualifier stretches the output period.

// File: rtl/ddc_agc_pkg.sv
package ddc_agc_pkg;

  typedef enum logic [1:0] {
    QUAD_0   = 2'd0,
    QUAD_90  = 2'd1,
    QUAD_180 = 2'd2,
    QUAD_270 = 2'd3
  } lo_quad_e;

  function automatic logic [7:0] clamp_ratio(input logic [7:0] req,
                                             input logic [7:0] lo,
                                             input logic [7:0] hi);
    if (req < lo)      return lo;
    else if (req > hi) return hi;
    else               return req;
  endfunction

endpackage

// File: rtl/ddc_agc_ctrl.sv
module ddc_agc_ctrl #(
  parameter int MAG_W    = 19,
  parameter int GAIN_W   = 2,
  parameter int GAIN_MAX = 3,
  parameter int UP_HOLD  = 16,
  parameter int HI_THR   = 16384,
  parameter int LO_THR   = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic              win_end,
  input  logic [MAG_W-1:0]  mag,
  output logic [GAIN_W-1:0] gain
);
  localparam int CNT_W = $clog2(UP_HOLD + 1);

  logic [MAG_W-1:0]  peak_q, peak_d, peak_cur;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [GAIN_W-1:0] gain_q, gain_d;

  always_comb begin
    peak_cur = (mag > peak_q) ? mag : peak_q;
    peak_d   = peak_q;
    cnt_d    = cnt_q;
    gain_d   = gain_q;
    if (smp_en) begin
      if (win_end) begin
        peak_d = '0;
        if (peak_cur > MAG_W'(HI_THR)) begin
          cnt_d = '0;
          if (gain_q != '0) gain_d = gain_q - 1'b1;
        end else if (peak_cur < MAG_W'(LO_THR)) begin
          if (cnt_q == CNT_W'(UP_HOLD - 1)) begin
            cnt_d = '0;
            if (gain_q < GAIN_W'(GAIN_MAX)) gain_d = gain_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else begin
          cnt_d = '0;
        end
      end else begin
        peak_d = peak_cur;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_q <= '0;
      cnt_q  <= '0;
      gain_q <= '0;
    end else if (smp_en) begin
      peak_q <= peak_d;
      cnt_q  <= cnt_d;
      gain_q <= gain_d;
    end
  end

  assign gain = gain_q;
endmodule

// File: rtl/ddc_agc_mixer.sv
module ddc_agc_mixer
  import ddc_agc_pkg::*;
#(
  parameter int IN_W  = 19,
  parameter int MIX_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_en,
  input  logic signed [IN_W-1:0]  smp,
  input  logic [1:0]              quad,
  output logic signed [MIX_W-1:0] mix_i,
  output logic signed [MIX_W-1:0] mix_q,
  output logic                    mix_vld
);
  logic signed [MIX_W-1:0] ext, neg, i_d, q_d;

  always_comb begin
    ext = MIX_W'(smp);
    neg = -ext;
    i_d = '0;
    q_d = '0;
    case (lo_quad_e'(quad))
      QUAD_0:   begin i_d = ext; q_d = '0;  end
      QUAD_90:  begin i_d = '0;  q_d = neg; end
      QUAD_180: begin i_d = neg; q_d = '0;  end
      default:  begin i_d = '0;  q_d = ext; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mix_i   <= '0;
      mix_q   <= '0;
      mix_vld <= 1'b0;
    end else begin
      mix_vld <= smp_en;
      if (smp_en) begin
        mix_i <= i_d;
        mix_q <= q_d;
      end
    end
  end
endmodule

// File: rtl/ddc_agc_cic.sv
module ddc_agc_cic #(
  parameter int IN_W   = 20,
  parameter int STAGES = 3,
  parameter int ACC_W  = 38,
  parameter int OUT_W  = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_en,
  input  logic signed [IN_W-1:0]  din,
  input  logic                    dump,
  output logic signed [OUT_W-1:0] dout,
  output logic                    dout_vld
);
  logic signed [ACC_W-1:0] integ  [STAGES];
  logic signed [ACC_W-1:0] dly    [STAGES];
  logic signed [ACC_W-1:0] cin    [STAGES];
  logic signed [ACC_W-1:0] cdiff  [STAGES];
  logic signed [ACC_W-1:0] din_x;

  assign din_x = ACC_W'(din);

  for (genvar k = 0; k < STAGES; k++) begin : g_int
    logic signed [ACC_W-1:0] src;
    if (k == 0) begin : g_first
      assign src = din_x;
    end else begin : g_chain
      assign src = integ[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     integ[k] <= '0;
      else if (in_en) integ[k] <= integ[k] + src;
    end
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_comb
    if (k == 0) begin : g_first
      assign cin[k] = integ[STAGES-1];
    end else begin : g_chain
      assign cin[k] = cdiff[k-1];
    end
    assign cdiff[k] = cin[k] - dly[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dly[k] <= '0;
      else if (dump) dly[k] <= cin[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= dump;
      if (dump) dout <= cdiff[STAGES-1][ACC_W-1 -: OUT_W];
    end
  end
endmodule

// File: rtl/ddc_agc_top.sv
module ddc_agc_top
  import ddc_agc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int GAIN_SH  = 3,
  parameter int STAGES   = 3,
  parameter int R_MIN    = 4,
  parameter int R_MAX    = 64,
  parameter int OUT_W    = 18,
  parameter int UP_HOLD  = 16,
  parameter int RATIO_W  = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        in_sample,
  input  logic [1:0]               lo_quad,
  input  logic [RATIO_W-1:0]       dec_ratio,
  output logic                     out_valid,
  output logic [OUT_W-1:0]         out_i,
  output logic [OUT_W-1:0]         out_q,
  output logic [$clog2(GAIN_SH+1)-1:0] out_gain
);
  localparam int GAIN_W = $clog2(GAIN_SH + 1);
  localparam int MAG_W  = DATA_W + GAIN_SH;
  localparam int MIX_W  = MAG_W + 1;
  localparam int ACC_W  = MIX_W + STAGES * $clog2(R_MAX);
  localparam int CNT_W  = $clog2(R_MAX);
  localparam int HI_THR = 2 ** (DATA_W - 2);
  localparam int LO_THR = 2 ** (DATA_W - 3);

  // reset: asserted asynchronously, released on the clock
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  // interval counter
  logic [7:0]       r_eff;
  logic [CNT_W-1:0] dcnt_q, dcnt_d;
  logic             win_end;

  always_comb begin
    r_eff   = clamp_ratio(8'(dec_ratio), 8'(R_MIN), 8'(R_MAX));
    win_end = in_valid && (8'(dcnt_q) >= (r_eff - 8'd1));
    dcnt_d  = dcnt_q;
    if (in_valid) dcnt_d = win_end ? '0 : dcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)        dcnt_q <= '0;
    else if (in_valid) dcnt_q <= dcnt_d;
  end

  // gain shift and magnitude
  logic [GAIN_W-1:0]       gain;
  logic signed [MAG_W-1:0] gx;
  logic [MAG_W-1:0]        mag;

  always_comb begin
    gx  = MAG_W'($signed(in_sample)) <<< gain;
    mag = gx[MAG_W-1] ? MAG_W'(-gx) : MAG_W'(gx);
  end

  ddc_agc_ctrl #(
    .MAG_W(MAG_W), .GAIN_W(GAIN_W), .GAIN_MAX(GAIN_SH),
    .UP_HOLD(UP_HOLD), .HI_THR(HI_THR), .LO_THR(LO_THR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_s), .smp_en(in_valid), .win_end(win_end),
    .mag(mag), .gain(gain)
  );

  logic signed [MIX_W-1:0] mix_i, mix_q;
  logic                    mix_vld;

  ddc_agc_mixer #(.IN_W(MAG_W), .MIX_W(MIX_W)) u_mix (
    .clk(clk), .rst_n(rst_s), .smp_en(in_valid), .smp(gx), .quad(lo_quad),
    .mix_i(mix_i), .mix_q(mix_q), .mix_vld(mix_vld)
  );

  // dump strobe aligned with the last mixer product of the interval
  logic dump_q;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) dump_q <= 1'b0;
    else        dump_q <= win_end;
  end

  logic signed [MIX_W-1:0] path_in [2];
  logic signed [OUT_W-1:0] path_out[2];
  logic [1:0]              path_vld;

  assign path_in[0] = mix_i;
  assign path_in[1] = mix_q;

  for (genvar c = 0; c < 2; c++) begin : g_path
    ddc_agc_cic #(
      .IN_W(MIX_W), .STAGES(STAGES), .ACC_W(ACC_W), .OUT_W(OUT_W)
    ) u_cic (
      .clk(clk), .rst_n(rst_s), .in_en(mix_vld), .din(path_in[c]),
      .dump(dump_q), .dout(path_out[c]), .dout_vld(path_vld[c])
    );
  end

  logic [GAIN_W-1:0] gain_out_q;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      gain_out_q <= '0;
    else if (dump_q) gain_out_q <= gain;
  end

  assign out_valid = path_vld[0];
  assign out_i     = path_out[0];
  assign out_q     = path_out[1];
  assign out_gain  = gain_out_q;
endmodule

// File: rtl/ddc_agc_chk.sv
module ddc_agc_chk #(
  parameter int GAIN_W = 2,
  parameter int OUT_W  = 18
) (
  input logic              clk,
  input logic              rst_s,
  input logic              win_end,
  input logic [GAIN_W-1:0] gain,
  input logic              out_valid,
  input logic [OUT_W-1:0]  out_i,
  input logic [OUT_W-1:0]  out_q,
  input logic [GAIN_W-1:0] out_gain
);
  // R8: shift moves only at an interval end
  p_gain_at_end_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (gain != $past(gain)) |-> $past(win_end));

  // R8: shift moves by at most one step
  p_gain_step_r8: assert property (@(posedge clk) disable iff (!rst_s)
    ((int'(gain) - int'($past(gain))) <= 1) && ((int'(gain) - int'($past(gain))) >= -1));

  // R4: strobe lasts one cycle
  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |=> !out_valid);

  // R10: results hold between strobes
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_s)
    !out_valid |-> ($stable(out_i) && $stable(out_q)));

  // R9: reported shift changes only with a strobe
  p_gain_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_s)
    !out_valid |-> $stable(out_gain));
endmodule

bind ddc_agc_top ddc_agc_chk #(.GAIN_W(GAIN_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_s(rst_s), .win_end(win_end), .gain(gain),
  .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .out_gain(out_gain)
);

// File: tb/ddc_agc_top_tb.sv
module ddc_agc_top_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_sample;
  logic [1:0]  lo_quad;
  logic [6:0]  dec_ratio;
  logic        out_valid;
  logic [17:0] out_i, out_q;
  logic [1:0]  out_gain;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int n       = 0;
  int mode    = 0;   // 0 const, 1 cosine tone, 2 sine tone
  int cval    = 0;
  int amp     = 0;
  int quad_fix = 0;  // -1 rotates with sample index
  bit gap     = 0;

  ddc_agc_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .lo_quad(lo_quad), .dec_ratio(dec_ratio), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q), .out_gain(out_gain)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // stimulus generator
  initial begin
    in_valid = 1'b0; in_sample = '0; lo_quad = '0;
    forever begin
      @(negedge clk);
      n = n + 1;
      in_valid = gap ? n[0] : 1'b1;
      case (mode)
        1: in_sample = 16'((n % 4 == 0) ? amp : (n % 4 == 2) ? -amp : 0);
        2: in_sample = 16'((n % 4 == 1) ? amp : (n % 4 == 3) ? -amp : 0);
        default: in_sample = 16'(cval);
      endcase
      lo_quad = (quad_fix < 0) ? 2'(n % 4) : 2'(quad_fix);
    end
  end

  function automatic longint expv(longint m, int r);
    return (m * r * r * r) >>> 20;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_out();
    do @(negedge clk); while (!out_valid);
  endtask

  task automatic skip_out(int k);
    for (int j = 0; j < k; j++) wait_out();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", out_valid, 0);
    chk("R1", "i in reset", out_i, 0);
    chk("R1", "q in reset", out_q, 0);
    chk("R1", "gain in reset", out_gain, 0);
    rst_n = 1'b1;
  endtask

  task automatic period(string req, int exp);
    int t0;
    wait_out();
    t0 = cyc;
    wait_out();
    chk(req, "strobe period", cyc - t0, exp);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    dec_ratio = 7'd16; mode = 0; cval = 1000; quad_fix = 0;
    do_reset();

    // R6: climb every 16 quiet intervals, cap at 3
    for (int k = 1; k <= 60; k++) begin
      wait_out();
      chk("R6", "gain climb", out_gain, (k / 16 > 3) ? 3 : k / 16);
    end
    // R2 / R3: all quadrants with constant input, shift 3
    chk("R3", "quad0 I", longint'($signed(out_i)), expv(8000, 16));
    chk("R2", "quad0 Q", longint'($signed(out_q)), 0);
    for (int qd = 1; qd < 4; qd++) begin
      quad_fix = qd;
      skip_out(4);
      chk("R2", "quad I", longint'($signed(out_i)),
          (qd == 2) ? expv(-8000, 16) : 0);
      chk("R2", "quad Q", longint'($signed(out_q)),
          (qd == 1) ? expv(-8000, 16) : (qd == 3) ? expv(8000, 16) : 0);
    end
    quad_fix = 0;
    skip_out(4);

    // R7: overload steps the shift down one per interval, stops in band
    cval = 5000;
    wait_out(); chk("R7", "drop 1", out_gain, 2);
    wait_out(); chk("R7", "drop 2", out_gain, 1);
    for (int k = 0; k < 4; k++) begin
      wait_out(); chk("R7", "hold in band", out_gain, 1);
    end
    chk("R3", "pos const", longint'($signed(out_i)), expv(10000, 16));
    cval = -5000;
    skip_out(4);
    chk("R3", "neg const", longint'($signed(out_i)), expv(-10000, 16));
    chk("R9", "gain with neg", out_gain, 1);

    // R7: overload at shift 0 stays at 0
    do_reset();
    cval = 20000;
    for (int k = 0; k < 3; k++) begin
      wait_out(); chk("R7", "floor at 0", out_gain, 0);
    end

    // R3: locked tones with rotating oscillator, shift stays 0
    do_reset();
    quad_fix = -1; amp = 12000; mode = 1;
    skip_out(5);
    chk("R3", "cos tone I", longint'($signed(out_i)), expv(6000, 16));
    chk("R3", "cos tone Q", longint'($signed(out_q)), 0);
    chk("R9", "tone gain", out_gain, 0);
    mode = 2;
    skip_out(4);
    chk("R3", "sin tone I", longint'($signed(out_i)), 0);
    chk("R3", "sin tone Q", longint'($signed(out_q)), expv(-6000, 16));

    // R4: ratio clamp sweep
    for (int r = 0; r <= 100; r += 4) begin
      int re;
      dec_ratio = 7'(r);
      re = (r < 4) ? 4 : (r > 64) ? 64 : r;
      wait_out();
      period("R4", re);
    end
    dec_ratio = 7'd2;   wait_out(); period("R4", 4);
    dec_ratio = 7'd100; wait_out(); period("R4", 64);

    // R5: qualifier gaps stretch the interval and leave the result
    do_reset();
    mode = 0; quad_fix = 0; cval = 12000; dec_ratio = 7'd4; gap = 1;
    skip_out(5);
    period("R5", 8);
    chk("R5", "value with gaps", longint'($signed(out_i)), expv(12000, 4));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule